// File: doc/BRIEF.md
# EDO DRAM Data-Pin Drive Model

This block is a synthesizable, device-side model of when an extended-data-out DRAM drives its data pins and when it releases them. It samples the four active-low strobes (row strobe, column strobe, write enable, output enable) and a multiplexed address on every clock. It keeps a small internal cell array and a held read-data register, and it produces a registered drive-enable for the data pins. It is intended as a behavioural peer in simulation, so a memory controller can be checked against the output turn-on and turn-off rules of this kind of memory.

The held read word loads only when the column strobe falls for a read. Raising the column strobe does not clear it, so data stays valid into the next page cycle. The drive-enable combines a read-valid flag, a write lockout, an output-enable park flag, the output-enable pin and the idle condition of both address strobes. Every strobe level is sampled at a rising clock edge. Both outputs change at that same edge and are visible one clock later.

Top module: `edo_dq_drive`

## Requirements
- R1: While rst_ni is low, and after it has been low, drv_o is 0 and dq_o is 0 until the first read.
- R2: A column-strobe fall (cas_ni 1 to 0) with ras_ni low and we_ni high is a read. dq_o takes the word stored at index {row, col}. The row comes from addr_i at the last ras_ni fall that happened with cas_ni high. The col comes from addr_i at the column-strobe fall. drv_o is 1 after that edge when oe_ni is low.
- R3: dq_o changes only on a read edge as defined in R2. After cas_ni rises with ras_ni low and oe_ni low, drv_o stays 1 and dq_o keeps the held word.
- R4: When ras_ni and cas_ni are both sampled high, drv_o is 0 after that edge. It stays 0 until the next read.
- R5: oe_ni sampled high forces drv_o to 0 after that edge. Lowering oe_ni again while cas_ni stays low drives the same held word again.
- R6: If oe_ni is high when cas_ni rises, drv_o stays 0 even with oe_ni low. This lasts until the next read edge.
- R7: A fall of we_ni forces drv_o to 0. It stays 0 until a read edge.
- R8: A column-strobe fall with ras_ni low and we_ni low is an early write. It stores dq_i at {row, addr_i col}, and drv_o stays 0 for the whole cycle, whatever oe_ni does.
- R9: A fall of we_ni while cas_ni is already low and ras_ni is low is a late write. It stores dq_i at {row, col latched at the column-strobe fall}. Taking oe_ni low again while cas_ni stays low keeps drv_o at 0.
- R10: A ras_ni fall while cas_ni is low latches no row, and it leaves dq_o and drv_o unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ras_ni | input | 1 | Row address strobe, active low |
| cas_ni | input | 1 | Column address strobe, active low |
| we_ni | input | 1 | Write enable, active low |
| oe_ni | input | 1 | Output enable, active low |
| addr_i | input | ADDR_W (3) | Multiplexed row/column address |
| dq_i | input | DATA_W (16) | Write data from the controller |
| drv_o | output | 1 | Data-pin drive enable, registered |
| dq_o | output | DATA_W (16) | Held read data |

## Verification
A stuck write lockout or park flag shows up as drv_o remaining 0 after the following read edge. A park or lockout that fails to set shows up as drv_o at 1 one clock after the offending strobe change. A held register that clears or reloads at the wrong time shows a changed dq_o at the first sample after a column-strobe rise or after a refresh-style row-strobe fall. A bad row or column latch shows up at the first read as the wrong stored word.

// File: rtl/edo_pkg.sv
package edo_pkg;
  localparam int STB_RAS = 0;
  localparam int STB_CAS = 1;
  localparam int STB_WE  = 2;
  localparam int NUM_EDGE_STB = 3;
endpackage

// File: rtl/edo_strobe_edge.sv
module edo_strobe_edge #(
  parameter int N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] stb_i,
  output logic [N-1:0] prev_o
);
  for (genvar g = 0; g < N; g++) begin : g_stb
    logic prev_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) prev_q <= 1'b1;
      else         prev_q <= stb_i[g];
    end
    assign prev_o[g] = prev_q;
  end
endmodule

// File: rtl/edo_cell_array.sv
module edo_cell_array #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              wen_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;
  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (wen_i) mem_q[waddr_i] <= wdata_i;
  end
  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/edo_drive_ctl.sv
module edo_drive_ctl
  import edo_pkg::*;
#(
  parameter int ROW_W  = 3,
  parameter int COL_W  = 3,
  parameter int ADDR_W = 3,
  parameter int DATA_W = 16,
  localparam int CELL_W = ROW_W + COL_W
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    ras_ni,
  input  logic                    cas_ni,
  input  logic                    we_ni,
  input  logic                    oe_ni,
  input  logic [NUM_EDGE_STB-1:0] prev_i,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [DATA_W-1:0]       rdata_i,
  output logic                    wen_o,
  output logic [CELL_W-1:0]       waddr_o,
  output logic [CELL_W-1:0]       raddr_o,
  output logic                    drv_o,
  output logic [DATA_W-1:0]       hold_o
);
  logic ras_fall, cas_fall, cas_rise, we_fall;
  logic rd_edge, early_wr, late_wr, idle;
  logic [ROW_W-1:0] row_q;
  logic [COL_W-1:0] col_q;
  logic live_q, lock_q, park_q, drv_q;
  logic live_d, lock_d, park_d;
  logic [DATA_W-1:0] hold_q;

  assign ras_fall = prev_i[STB_RAS] & ~ras_ni;
  assign cas_fall = prev_i[STB_CAS] & ~cas_ni;
  assign cas_rise = ~prev_i[STB_CAS] & cas_ni;
  assign we_fall  = prev_i[STB_WE]  & ~we_ni;

  assign rd_edge  = cas_fall & ~ras_ni & we_ni;
  assign early_wr = cas_fall & ~ras_ni & ~we_ni;
  assign late_wr  = we_fall & ~cas_ni & ~cas_fall & ~ras_ni;
  assign idle     = ras_ni & cas_ni;

  assign raddr_o = {row_q, addr_i[COL_W-1:0]};
  assign wen_o   = early_wr | late_wr;
  assign waddr_o = early_wr ? {row_q, addr_i[COL_W-1:0]} : {row_q, col_q};

  // next-state of the drive qualifiers
  always_comb begin
    live_d = live_q;
    lock_d = lock_q;
    park_d = park_q;
    if (idle)                live_d = 1'b0;
    if (we_fall || early_wr) lock_d = 1'b1;
    if (cas_rise && oe_ni)   park_d = 1'b1;
    if (rd_edge) begin
      live_d = 1'b1;
      lock_d = 1'b0;
      park_d = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      row_q  <= '0;
      col_q  <= '0;
      live_q <= 1'b0;
      lock_q <= 1'b0;
      park_q <= 1'b0;
      drv_q  <= 1'b0;
      hold_q <= '0;
    end else begin
      if (ras_fall && cas_ni) row_q <= addr_i[ROW_W-1:0];
      if (cas_fall)           col_q <= addr_i[COL_W-1:0];
      if (rd_edge)            hold_q <= rdata_i;
      live_q <= live_d;
      lock_q <= lock_d;
      park_q <= park_d;
      drv_q  <= live_d & ~lock_d & ~park_d & ~oe_ni & ~idle;
    end
  end

  assign drv_o  = drv_q;
  assign hold_o = hold_q;
endmodule

// File: rtl/edo_dq_drive.sv
module edo_dq_drive
  import edo_pkg::*;
#(
  parameter int ROW_W  = 3,
  parameter int COL_W  = 3,
  parameter int DATA_W = 16,
  localparam int ADDR_W = (ROW_W > COL_W) ? ROW_W : COL_W,
  localparam int CELL_W = ROW_W + COL_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ras_ni,
  input  logic              cas_ni,
  input  logic              we_ni,
  input  logic              oe_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] dq_i,
  output logic              drv_o,
  output logic [DATA_W-1:0] dq_o
);
  logic [NUM_EDGE_STB-1:0] stb, prev;
  logic                    wen;
  logic [CELL_W-1:0]       waddr, raddr;
  logic [DATA_W-1:0]       rdata;

  always_comb begin
    stb          = '1;
    stb[STB_RAS] = ras_ni;
    stb[STB_CAS] = cas_ni;
    stb[STB_WE]  = we_ni;
  end

  edo_strobe_edge #(.N(NUM_EDGE_STB)) u_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .stb_i (stb),
    .prev_o(prev)
  );

  edo_cell_array #(.ADDR_W(CELL_W), .DATA_W(DATA_W)) u_cells (
    .clk_i  (clk_i),
    .wen_i  (wen),
    .waddr_i(waddr),
    .wdata_i(dq_i),
    .raddr_i(raddr),
    .rdata_o(rdata)
  );

  edo_drive_ctl #(
    .ROW_W(ROW_W), .COL_W(COL_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_ctl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ras_ni (ras_ni),
    .cas_ni (cas_ni),
    .we_ni  (we_ni),
    .oe_ni  (oe_ni),
    .prev_i (prev),
    .addr_i (addr_i),
    .rdata_i(rdata),
    .wen_o  (wen),
    .waddr_o(waddr),
    .raddr_o(raddr),
    .drv_o  (drv_o),
    .hold_o (dq_o)
  );
endmodule

// File: rtl/edo_dq_drive_chk.sv
module edo_dq_drive_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ras_ni,
  input logic              cas_ni,
  input logic              we_ni,
  input logic              oe_ni,
  input logic              drv_o,
  input logic [DATA_W-1:0] dq_o
);
  AST_IDLE_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ras_ni && cas_ni) |=> !drv_o); // R4

  AST_OE_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_ni |=> !drv_o); // R5

  AST_WE_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(we_ni) |=> !drv_o); // R7

  AST_EARLY_WR_OPEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(cas_ni) && !ras_ni && !we_ni) |=> !drv_o); // R8

  AST_HOLD_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !($fell(cas_ni) && !ras_ni && we_ni) |=> $stable(dq_o)); // R3
endmodule

bind edo_dq_drive edo_dq_drive_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i (clk_i),
  .rst_ni(rst_ni),
  .ras_ni(ras_ni),
  .cas_ni(cas_ni),
  .we_ni (we_ni),
  .oe_ni (oe_ni),
  .drv_o (drv_o),
  .dq_o  (dq_o)
);

// File: tb/edo_dq_drive_test.sv
module edo_dq_drive_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [2:0] addr = '0;
  logic [15:0] din = '0;
  logic drv;
  logic [15:0] dq;
  int checks = 0;
  int fails = 0;

  always #4 clk = ~clk;

  edo_dq_drive uut (
    .clk_i(clk), .rst_ni(rst_n), .ras_ni(ras_n), .cas_ni(cas_n),
    .we_ni(we_n), .oe_ni(oe_n), .addr_i(addr), .dq_i(din),
    .drv_o(drv), .dq_o(dq)
  );

  typedef struct packed {
    logic ras, cas, we, oe;
    logic [2:0]  a;
    logic [15:0] d;
    logic        edrv;
    logic [15:0] edq;
    logic        cdq;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 24;
  localparam vec_t VEC [NV] = '{
    '{0,1,0,1, 3'd2, 16'h0000, 0, 16'h0000, 0, 4'd7},  // R7 we falls, row 2
    '{0,0,0,1, 3'd5, 16'hA5A5, 0, 16'h0000, 0, 4'd8},  // R8 early write col 5
    '{0,0,0,0, 3'd5, 16'h0000, 0, 16'h0000, 0, 4'd8},  // R8 oe low, still open
    '{0,1,1,0, 3'd0, 16'h0000, 0, 16'h0000, 0, 4'd7},  // R7 lock holds
    '{0,0,1,0, 3'd5, 16'h0000, 1, 16'hA5A5, 1, 4'd2},  // R2 read
    '{0,1,1,0, 3'd0, 16'h0000, 1, 16'hA5A5, 1, 4'd3},  // R3 extended data
    '{1,1,1,0, 3'd0, 16'h0000, 0, 16'hA5A5, 1, 4'd4},  // R4 idle
    '{0,1,1,1, 3'd2, 16'h0000, 0, 16'hA5A5, 1, 4'd4},  // R4 no read yet
    '{0,0,0,1, 3'd3, 16'h1234, 0, 16'hA5A5, 1, 4'd8},  // R8 early write col 3
    '{0,1,1,1, 3'd0, 16'h0000, 0, 16'hA5A5, 1, 4'd8},
    '{0,0,1,0, 3'd3, 16'h0000, 1, 16'h1234, 1, 4'd2},  // R2
    '{0,0,1,1, 3'd0, 16'h0000, 0, 16'h1234, 1, 4'd5},  // R5 oe high
    '{0,0,1,0, 3'd0, 16'h0000, 1, 16'h1234, 1, 4'd5},  // R5 oe low again
    '{0,1,1,1, 3'd0, 16'h0000, 0, 16'h1234, 1, 4'd6},  // R6 park
    '{0,1,1,0, 3'd0, 16'h0000, 0, 16'h1234, 1, 4'd6},  // R6 still parked
    '{0,0,1,0, 3'd5, 16'h0000, 1, 16'hA5A5, 1, 4'd6},  // R6 cleared by read
    '{0,0,1,1, 3'd0, 16'h0000, 0, 16'hA5A5, 1, 4'd5},
    '{0,0,0,1, 3'd0, 16'hBEEF, 0, 16'hA5A5, 1, 4'd9},  // R9 late write
    '{0,0,1,0, 3'd0, 16'h0000, 0, 16'hA5A5, 1, 4'd9},  // R9 stays open
    '{0,1,1,0, 3'd0, 16'h0000, 0, 16'hA5A5, 1, 4'd9},
    '{0,0,1,0, 3'd5, 16'h0000, 1, 16'hBEEF, 1, 4'd9},  // R9 stored at col 5
    '{1,0,1,0, 3'd0, 16'h0000, 1, 16'hBEEF, 1, 4'd3},
    '{0,0,1,0, 3'd6, 16'h0000, 1, 16'hBEEF, 1, 4'd10}, // R10 ras falls, cas low
    '{1,1,1,0, 3'd0, 16'h0000, 0, 16'hBEEF, 1, 4'd4}   // R4
  };

  task automatic step(input logic r, c, w, o, input logic [2:0] a, input logic [15:0] d);
    ras_n = r; cas_n = c; we_n = w; oe_n = o; addr = a; din = d;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string tag, input logic edrv, input logic [15:0] edq, input logic cdq);
    checks++;
    if (drv !== edrv) begin
      fails++;
      $display("FAIL %s drv_o act=%0b exp=%0b", tag, drv, edrv);
    end else if (cdq && dq !== edq) begin
      fails++;
      $display("FAIL %s dq_o act=%h exp=%h", tag, dq, edq);
    end
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog act=running exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", 1'b0, 16'h0000, 1'b1);
    rst_n = 1'b1;
    @(negedge clk);
    for (int i = 0; i < NV; i++) begin
      step(VEC[i].ras, VEC[i].cas, VEC[i].we, VEC[i].oe, VEC[i].a, VEC[i].d);
      check($sformatf("R%0d", VEC[i].req), VEC[i].edrv, VEC[i].edq, VEC[i].cdq);
    end
    // R2 rows kept apart
    step(0,1,1,1, 3'd3, 16'h0000);
    step(0,0,0,1, 3'd5, 16'h0F0F);
    step(0,1,1,1, 3'd0, 16'h0000);
    step(0,0,1,0, 3'd5, 16'h0000);
    check("R2", 1'b1, 16'h0F0F, 1'b1);
    step(0,1,1,0, 3'd0, 16'h0000);
    check("R3", 1'b1, 16'h0F0F, 1'b1);
    step(1,1,1,1, 3'd0, 16'h0000);
    step(0,1,1,1, 3'd2, 16'h0000);
    step(0,0,1,0, 3'd5, 16'h0000);
    check("R2", 1'b1, 16'hBEEF, 1'b1);
    // R10 refresh-style ras fall keeps row latch too
    step(1,0,1,0, 3'd0, 16'h0000);
    step(0,0,1,0, 3'd3, 16'h0000);
    check("R10", 1'b1, 16'hBEEF, 1'b1);
    step(0,1,1,0, 3'd0, 16'h0000);
    step(0,0,1,0, 3'd5, 16'h0000);
    check("R10", 1'b1, 16'hBEEF, 1'b1);
    // R1 reset mid-read
    rst_n = 1'b0;
    #1;
    check("R1", 1'b0, 16'h0000, 1'b1);
    step(1,1,1,1, 3'd0, 16'h0000);
    rst_n = 1'b1;
    step(1,1,1,0, 3'd0, 16'h0000);
    check("R1", 1'b0, 16'h0000, 1'b1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule